// File: doc/BRIEF.md
# Reset Sequencer with Pin Stretching

This block decides when a small processor core may leave reset. It watches two reset sources. The first is an active-low external reset pin that is shared with the block's own open-drain pull-down. The second is a supply monitor flag that is high while the supply is too low, which covers both power-up and a later supply dip. A recognised event makes the block pull the pin low for a guaranteed minimum time. It holds the core in reset for a selectable number of clock cycles after the pin is seen high again. It then issues a single-cycle vector-fetch strobe in the cycle the core reset is released.

The sequencer has five states. RUN is normal operation. ACTIVE drives the pin low. RELEASE waits for the pin to read high. DELAY counts the internal delay. FETCH is the one cycle that carries the strobe. The transitions are:
- RUN→ACTIVE on a recognised event.
- ACTIVE→RELEASE once the minimum drive time has elapsed and the supply flag is no longer recognised.
- RELEASE→ACTIVE on a recognised supply event.
- RELEASE→DELAY when both synchronised inputs read inactive.
- DELAY→FETCH when the count expires.
- DELAY→ACTIVE and FETCH→ACTIVE on any recognised event.
- FETCH→RUN otherwise.

A power-up clear input forces ACTIVE. The pin also sets the core reset at once through an asynchronous path, so reset is entered with the clock stopped.

Top module: `reset_sequencer`

## Requirements
- R1: While `por_n` is low: `core_rst`=1, `pin_pull`=1, `fetch_vec`=0, `flag_pin`=0 and `flag_lvd`=0. After release, the pull lasts MIN_OUT cycles (the last edge is MIN_OUT-1 edges after the first).
- R2: A low level on `ext_rst_n` raises `core_rst` with no clock edge. If the low is not recognised, `core_rst` falls after the second rising edge at which the pin is sampled high.
- R3: If the pin is sampled low at fewer than MIN_IN (default 4) consecutive rising edges, nothing changes: no pull, no strobe, no flag.
- R4: If the pin is sampled low at MIN_IN or more edges, `pin_pull` rises MIN_IN+2 edges after the first low sample and stays high for exactly MIN_OUT cycles (default 16).
- R5: A pin pulse longer than the pull is not extended. The DELAY state begins two edges after the first edge at which the pin is sampled high.
- R6: If `lvd_low` is high at fewer than LVD_FILT (default 8) consecutive sampling edges, it has no effect.
- R7: If `lvd_low` is high at W ≥ LVD_FILT samples, `pin_pull` rises LVD_FILT+2 edges after the first sample. It falls at the later of MIN_OUT cycles after that and W+3 edges after the first sample.
- R8: DELAY lasts DLY_SHORT cycles (default 256) when `long_delay`=0, and DLY_LONG cycles (default 4096) when `long_delay`=1. The count starts two edges after the pin is first sampled high.
- R9: `fetch_vec` is high for exactly one cycle. `core_rst` falls in that same cycle, and no other fetch follows without a new event.
- R10: A recognised event during DELAY or FETCH restarts the sequence at ACTIVE. The interrupted sequence produces no strobe.
- R11: On entry to ACTIVE, exactly one flag is set: `flag_lvd` if the supply event is recognised in that cycle, otherwise `flag_pin`. The other flag is cleared. A high `flag_clr` clears both flags unless an entry happens in the same cycle.
- R12: `core_rst` is high whenever `pin_pull` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| por_n | input | 1 | Asynchronous power-up clear, active low |
| ext_rst_n | input | 1 | Level read back from the shared reset pin, active low |
| lvd_low | input | 1 | Supply monitor flag, high while the supply is low |
| long_delay | input | 1 | Static delay select: 0 short, 1 long |
| flag_clr | input | 1 | Clears both source flags |
| core_rst | output | 1 | Core reset, active high |
| fetch_vec | output | 1 | One-cycle vector-fetch strobe |
| pin_pull | output | 1 | Enable for the open-drain pull-down on the reset pin |
| flag_pin | output | 1 | Last reset came from the pin |
| flag_lvd | output | 1 | Last reset came from the supply monitor |

## Verification
Each input pulse is driven just after a falling edge, so the first rising edge afterwards is sample zero. Every result is then due at a fixed edge count from sample zero:
- the pull rises at MIN_IN+2 (pin) or LVD_FILT+2 (supply);
- the pull falls MIN_OUT later, or at W+3 for a long supply pulse;
- DELAY begins two edges after the pin reads high;
- the strobe comes after DLY_SHORT or DLY_LONG further edges.

A falling-edge monitor records the edge index of each output transition. The bench compares those indices with the values computed from these formulas, sweeping every pulse width from one sample to several beyond the pull length.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
    typedef enum logic [2:0] {
        SQ_RUN,
        SQ_ACTIVE,
        SQ_RELEASE,
        SQ_DELAY,
        SQ_FETCH
    } seq_state_e;
endpackage

// File: rtl/rstseq_filt.sv
// Two-flop synchroniser followed by a run-length qualifier:
// hit is high once the synchronised level has been active for HITS samples.
module rstseq_filt #(
    parameter int unsigned HITS = 4
) (
    input  logic clk,
    input  logic arst_n,
    input  logic raw_act,
    output logic act_s,
    output logic hit
);
    localparam int unsigned CW = $clog2(HITS + 1);

    logic          s1, s2;
    logic [CW-1:0] run;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            s1  <= 1'b0;
            s2  <= 1'b0;
            run <= '0;
        end else begin
            s1 <= raw_act;
            s2 <= s1;
            if (!s2) begin
                run <= '0;
            end else if (run != CW'(HITS)) begin
                run <= run + 1'b1;
            end
        end
    end

    assign act_s = s2;
    assign hit   = (run == CW'(HITS));
endmodule

// File: rtl/rstseq_hold.sv
// Asynchronous set, two-stage synchronous release.
module rstseq_hold (
    input  logic clk,
    input  logic arst_n,
    output logic hold
);
    logic h1, h2;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            h1 <= 1'b1;
            h2 <= 1'b1;
        end else begin
            h1 <= 1'b0;
            h2 <= h1;
        end
    end

    assign hold = h2;
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
    import rstseq_pkg::*;
#(
    parameter int unsigned MIN_IN    = 4,
    parameter int unsigned MIN_OUT   = 16,
    parameter int unsigned LVD_FILT  = 8,
    parameter int unsigned DLY_SHORT = 256,
    parameter int unsigned DLY_LONG  = 4096
) (
    input  logic clk,
    input  logic por_n,
    input  logic ext_rst_n,
    input  logic lvd_low,
    input  logic long_delay,
    input  logic flag_clr,
    output logic core_rst,
    output logic fetch_vec,
    output logic pin_pull,
    output logic flag_pin,
    output logic flag_lvd
);
    localparam int unsigned DMAX = (DLY_LONG > DLY_SHORT) ? DLY_LONG : DLY_SHORT;
    localparam int unsigned CMAX = (DMAX > MIN_OUT) ? DMAX : MIN_OUT;
    localparam int unsigned CW   = $clog2(CMAX + 1);

    seq_state_e    state, state_n;
    logic [CW-1:0] cnt, cnt_n;
    logic          pin_act_s, pin_hit, lvd_act_s, lvd_hit;
    logic          hold, hold_arst_n, seq_rst, any_hit, entering;
    logic [CW-1:0] dly_last;

    // Source qualifiers
    rstseq_filt #(.HITS(MIN_IN)) u_pin_filt (
        .clk(clk), .arst_n(por_n), .raw_act(~ext_rst_n),
        .act_s(pin_act_s), .hit(pin_hit)
    );

    rstseq_filt #(.HITS(LVD_FILT)) u_lvd_filt (
        .clk(clk), .arst_n(por_n), .raw_act(lvd_low),
        .act_s(lvd_act_s), .hit(lvd_hit)
    );

    // Clock-independent entry path from the pin
    assign hold_arst_n = ext_rst_n & por_n;

    rstseq_hold u_hold (
        .clk(clk), .arst_n(hold_arst_n), .hold(hold)
    );

    assign any_hit  = pin_hit | lvd_hit;
    assign dly_last = long_delay ? CW'(DLY_LONG - 1) : CW'(DLY_SHORT - 1);

    // Next state and phase counter
    always_comb begin
        state_n = state;
        unique case (state)
            SQ_RUN: begin
                if (any_hit) state_n = SQ_ACTIVE;
            end
            SQ_ACTIVE: begin
                if (cnt == CW'(MIN_OUT - 1) && !lvd_hit) state_n = SQ_RELEASE;
            end
            SQ_RELEASE: begin
                if (lvd_hit)                       state_n = SQ_ACTIVE;
                else if (!pin_act_s && !lvd_act_s) state_n = SQ_DELAY;
            end
            SQ_DELAY: begin
                if (any_hit)              state_n = SQ_ACTIVE;
                else if (cnt == dly_last) state_n = SQ_FETCH;
            end
            SQ_FETCH: begin
                state_n = any_hit ? SQ_ACTIVE : SQ_RUN;
            end
            default: state_n = SQ_ACTIVE;
        endcase

        if (state_n != state) begin
            cnt_n = '0;
        end else if (state == SQ_ACTIVE && cnt != CW'(MIN_OUT - 1)) begin
            cnt_n = cnt + 1'b1;
        end else if (state == SQ_DELAY) begin
            cnt_n = cnt + 1'b1;
        end else begin
            cnt_n = cnt;
        end
    end

    assign entering = (state_n == SQ_ACTIVE) && (state != SQ_ACTIVE);

    // State register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state <= SQ_ACTIVE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // Registered outputs, decoded from the next state
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            seq_rst   <= 1'b1;
            pin_pull  <= 1'b1;
            fetch_vec <= 1'b0;
            flag_pin  <= 1'b0;
            flag_lvd  <= 1'b0;
        end else begin
            seq_rst   <= (state_n != SQ_RUN) && (state_n != SQ_FETCH);
            pin_pull  <= (state_n == SQ_ACTIVE);
            fetch_vec <= (state_n == SQ_FETCH);
            if (entering) begin
                flag_lvd <= lvd_hit;
                flag_pin <= ~lvd_hit;
            end else if (flag_clr) begin
                flag_lvd <= 1'b0;
                flag_pin <= 1'b0;
            end
        end
    end

    assign core_rst = seq_rst | hold;
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk #(
    parameter int unsigned MIN_OUT = 16
) (
    input logic clk,
    input logic por_n,
    input logic flag_clr,
    input logic core_rst,
    input logic fetch_vec,
    input logic pin_pull,
    input logic flag_pin,
    input logic flag_lvd
);
    int unsigned pull_run;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            pull_run <= 0;
        end else if (pin_pull) begin
            if (pull_run < MIN_OUT) pull_run <= pull_run + 1;
        end else begin
            pull_run <= 0;
        end
    end

    // R1
    por_state_chk: assert property (@(posedge clk)
        !por_n |-> (core_rst && pin_pull && !fetch_vec));

    // R4
    pull_min_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!pin_pull && $past(pin_pull)) |-> (pull_run == MIN_OUT));

    // R9
    fetch_single_chk: assert property (@(posedge clk) disable iff (!por_n)
        fetch_vec |=> !fetch_vec);

    // R9
    fetch_release_chk: assert property (@(posedge clk) disable iff (!por_n)
        fetch_vec |-> (!core_rst && $past(core_rst)));

    // R12
    pull_core_chk: assert property (@(posedge clk) disable iff (!por_n)
        pin_pull |-> core_rst);

    // R11
    flag_excl_chk: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0({flag_pin, flag_lvd}));

    // R11
    flag_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
        flag_clr |=> ($rose(pin_pull) || !(flag_pin || flag_lvd)));
endmodule

bind reset_sequencer rstseq_chk #(.MIN_OUT(MIN_OUT)) u_rstseq_chk (
    .clk(clk), .por_n(por_n), .flag_clr(flag_clr), .core_rst(core_rst),
    .fetch_vec(fetch_vec), .pin_pull(pin_pull),
    .flag_pin(flag_pin), .flag_lvd(flag_lvd)
);

// File: tb/test_reset_sequencer.sv
module test_reset_sequencer;
    localparam int MI = 3;
    localparam int MO = 8;
    localparam int LF = 5;
    localparam int DS = 16;
    localparam int DL = 40;

    logic clk = 1'b0;
    logic por_n = 1'b1;
    logic drv_low = 1'b0;
    logic lvd_low = 1'b0;
    logic long_delay = 1'b0;
    logic flag_clr = 1'b0;
    logic ext_rst_n, core_rst, fetch_vec, pin_pull, flag_pin, flag_lvd;

    // wired pin: external driver or own pull-down
    assign ext_rst_n = ~(drv_low | pin_pull);

    always #4 clk = ~clk;

    reset_sequencer #(
        .MIN_IN(MI), .MIN_OUT(MO), .LVD_FILT(LF), .DLY_SHORT(DS), .DLY_LONG(DL)
    ) i_reset_sequencer (
        .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .lvd_low(lvd_low),
        .long_delay(long_delay), .flag_clr(flag_clr), .core_rst(core_rst),
        .fetch_vec(fetch_vec), .pin_pull(pin_pull),
        .flag_pin(flag_pin), .flag_lvd(flag_lvd)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int n_pr, t_pr, t_pf, n_f, t_f, t_cf;
    logic pull_q = 1'b1;
    logic core_q = 1'b1;

    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        if (pin_pull && !pull_q) begin n_pr++; t_pr = cyc; end
        if (!pin_pull && pull_q) t_pf = cyc;
        if (fetch_vec) begin n_f++; t_f = cyc; end
        if (!core_rst && core_q) t_cf = cyc;
        pull_q = pin_pull;
        core_q = core_rst;
    end

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_rec();
        n_pr = 0; t_pr = -1; t_pf = -1; n_f = 0; t_f = -1; t_cf = -1;
    endtask

    task automatic pulse_clr();
        @(negedge clk); #1 flag_clr = 1'b1;
        @(negedge clk); #1 flag_clr = 1'b0;
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    task automatic run_pin(input int len, input bit sel);
        int e0, d, eh, a;
        d = sel ? DL : DS;
        long_delay = sel;
        pulse_clr();
        clear_rec();
        @(negedge clk); #1 drv_low = 1'b1;
        e0 = cyc + 1;
        #1 chk("R2 async core_rst on pin low", int'(core_rst), 1);
        repeat (len) @(negedge clk);
        #1 drv_low = 1'b0;
        repeat (MI + MO + d + 14) @(negedge clk);
        if (len < MI) begin
            chk("R3 short pin pulse no pull", n_pr, 0);
            chk("R3 short pin pulse no fetch", n_f, 0);
            chk("R3 short pin pulse no flag", int'({flag_pin, flag_lvd}), 0);
            chk("R2 core_rst release edge", t_cf, e0 + len + 1);
        end else begin
            a  = e0 + MI + 2;
            eh = imax(e0 + len, a + MO + 1);
            chk("R4 pull count", n_pr, 1);
            chk("R4 pull rise edge", t_pr, a);
            chk(len > MI + 2 + MO ? "R5 long pulse pull width" : "R4 stretch width",
                t_pf - t_pr, MO);
            chk(sel ? "R8 fetch edge long" : "R8 fetch edge short", t_f, eh + 2 + d);
            chk("R9 single fetch", n_f, 1);
            chk("R9 core_rst falls with fetch", t_cf, t_f);
            chk("R11 pin flag", int'({flag_pin, flag_lvd}), 2);
        end
    endtask

    task automatic run_lvd(input int w, input bit sel);
        int e0, d, a, x;
        d = sel ? DL : DS;
        long_delay = sel;
        pulse_clr();
        clear_rec();
        @(negedge clk); #1 lvd_low = 1'b1;
        e0 = cyc + 1;
        repeat (w) @(negedge clk);
        #1 lvd_low = 1'b0;
        repeat (LF + MO + d + 16) @(negedge clk);
        if (w < LF) begin
            chk("R6 lvd spike no pull", n_pr, 0);
            chk("R6 lvd spike no fetch", n_f, 0);
            chk("R6 lvd spike core_rst low", int'(core_rst), 0);
        end else begin
            a = e0 + LF + 2;
            x = imax(a + MO, e0 + w + 3);
            chk("R7 lvd pull rise edge", t_pr, a);
            chk("R7 lvd pull fall edge", t_pf, x);
            chk(sel ? "R8 lvd fetch long" : "R8 lvd fetch short", t_f, x + 3 + d);
            chk("R9 lvd single fetch", n_f, 1);
            chk("R11 lvd flag", int'({flag_pin, flag_lvd}), 1);
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        report();
        $finish;
    end

    initial begin
        int e0, x, de;
        clear_rec();
        #2 por_n = 1'b0;
        #20;
        chk("R1 reset core_rst", int'(core_rst), 1);
        chk("R1 reset pin_pull", int'(pin_pull), 1);
        chk("R1 reset fetch", int'(fetch_vec), 0);
        chk("R1 reset flags", int'({flag_pin, flag_lvd}), 0);
        @(negedge clk); #1 por_n = 1'b1;
        e0 = cyc + 1;
        repeat (MO + DS + 20) @(negedge clk);
        x = e0 + MO - 1;
        chk("R1 boot pull fall edge", t_pf, x);
        chk("R8 boot fetch edge", t_f, x + 3 + DS);
        chk("R9 boot core_rst with fetch", t_cf, t_f);

        for (int len = 1; len <= MI + MO + 5; len++) run_pin(len, len[0]);
        for (int w = 1; w <= LF + MO + 4; w++) run_lvd(w, w[0]);

        // R10: supply event during DELAY restarts the sequence
        long_delay = 1'b0;
        pulse_clr();
        @(negedge clk); #1 drv_low = 1'b1;
        e0 = cyc + 1;
        repeat (MI) @(negedge clk);
        #1 drv_low = 1'b0;
        de = e0 + MI + 3 + MO + 2;
        while (cyc < de + 3) @(negedge clk);
        clear_rec();
        #1 lvd_low = 1'b1;
        e0 = cyc + 1;
        repeat (LF) @(negedge clk);
        #1 lvd_low = 1'b0;
        repeat (LF + MO + DS + 16) @(negedge clk);
        x = e0 + LF + 2 + MO;
        chk("R10 restart pull rise", t_pr, e0 + LF + 2);
        chk("R10 restart fetch edge", t_f, x + 3 + DS);
        chk("R10 no fetch from aborted run", n_f, 1);
        chk("R11 last source replaces flag", int'({flag_pin, flag_lvd}), 1);

        // R11: simultaneous recognition gives the supply flag
        pulse_clr();
        clear_rec();
        @(negedge clk); #1 lvd_low = 1'b1;
        repeat (2) @(negedge clk);
        #1 drv_low = 1'b1;
        repeat (5) @(negedge clk);
        #1 begin drv_low = 1'b0; lvd_low = 1'b0; end
        repeat (MO + DS + 24) @(negedge clk);
        chk("R11 priority flag", int'({flag_pin, flag_lvd}), 1);
        chk("R9 priority single fetch", n_f, 1);

        pulse_clr();
        @(negedge clk);
        chk("R11 flag_clr clears", int'({flag_pin, flag_lvd}), 0);

        report();
        $finish;
    end
endmodule